// File: doc/BRIEF.md
# Hashed control-state coverage monitor

This block watches a group of control registers of a design under test and measures how many distinct control states have been seen. On every clock edge it folds the register values into a short state index. Each register value is shifted left by a fixed offset of its own, and all shifted values are combined by XOR. The index selects one bit in a bitmap of visited states, and that bit is set.

A counter of distinct states steps up only when the selected bit was still clear. Whenever that happens, a one-cycle pulse flags the new state. A synchronous clear empties the bitmap and the counter in a single cycle.

Several monitors can be chained into a tree. Each instance adds the totals of its children to its own count, so the root presents coverage for the whole hierarchy.

Top module: `ctl_cov_mon`

## Requirements
- R1: `hash_o` is updated on every rising clock edge. Its new value is the XOR over k of the low `IDX_W` bits of `ctl_i` field k, shifted left by `(OFF_BASE + k*OFF_STEP) mod IDX_W`. Field k is `ctl_i[k*REG_W +: REG_W]`. With the defaults (4 fields of 8 bits, `IDX_W`=8, base 0, step 3) the shifts are 0, 3, 6 and 1.
- R2: A state index whose bitmap slot is already set produces `new_o`=0 after the edge and leaves `cnt_o` unchanged.
- R3: A state index whose slot is still clear sets the slot. After that edge, `new_o` is 1 for exactly one cycle and `cnt_o` rises by one.
- R4: `cnt_o` saturates at `2**CNT_W-1` (255 by default) and does not wrap. `new_o` still pulses for new states while `cnt_o` is saturated.
- R5: With `clr_i`=1 at an edge, the whole bitmap and `cnt_o` are 0 after that edge and `new_o` is 0. The state presented in that cycle is not marked. `hash_o` still tracks the input.
- R6: `tot_o` equals `cnt_o` plus the sum of the `CHILD_N` fields of `child_cnt_i` (field i is `child_cnt_i[i*CNT_W +: CNT_W]`), saturated at `2**CNT_W-1`. It follows its inputs combinationally.
- R7: While `rst_ni` is low, `hash_o`, `cnt_o` and `new_o` are 0 and the bitmap is empty.
- R8: Different states presented on consecutive cycles are each evaluated, so back-to-back new states give back-to-back `new_o` pulses and count steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of bitmap and counter |
| ctl_i | input | NUM_REGS*REG_W | Monitored control register values, packed |
| child_cnt_i | input | CHILD_N*CNT_W | Totals from child monitors |
| hash_o | output | IDX_W | Registered state index |
| new_o | output | 1 | Pulse for a first visit to a state |
| cnt_o | output | CNT_W | Distinct states seen by this instance |
| tot_o | output | CNT_W | Saturated sum of own and child counts |

## Verification
The hardest condition to reach from the ports is saturation. The counter only stops at 255 after 255 different slots have been filled, and random register values keep landing on slots that are already set. The bench clears the monitor and then sweeps the first field through all 256 values while the other fields stay at zero. Because that field has a shift of zero, every slot is hit exactly once. The last value in the sweep then gives a new-state pulse while the count holds at its ceiling.

// File: rtl/ctl_cov_pkg.sv
package ctl_cov_pkg;
  function automatic int unsigned shift_of(int unsigned k, int unsigned base,
                                           int unsigned step, int unsigned idx_w);
    return (base + k * step) % idx_w;
  endfunction
endpackage

// File: rtl/cov_hash.sv
module cov_hash import ctl_cov_pkg::*; #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned OFF_BASE = 0,
  parameter int unsigned OFF_STEP = 3
) (
  input  logic [NUM_REGS*REG_W-1:0] ctl_i,
  output logic [IDX_W-1:0]          idx_o
);
  localparam int unsigned TW = REG_W + IDX_W;

  logic [IDX_W-1:0] term_w [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_term
    localparam int unsigned SH = shift_of(k, OFF_BASE, OFF_STEP, IDX_W);
    logic [TW-1:0] wide_w;
    assign wide_w    = {{IDX_W{1'b0}}, ctl_i[k*REG_W +: REG_W]} << SH;
    assign term_w[k] = wide_w[IDX_W-1:0];
  end

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < NUM_REGS; k++) idx_o ^= term_w[k];
  end
endmodule

// File: rtl/cov_bitmap.sv
module cov_bitmap #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             set_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             hit_o
);
  localparam int unsigned SLOTS = 1 << IDX_W;

  logic [SLOTS-1:0] map_q;

  assign hit_o = map_q[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    map_q <= '0;
    else if (clr_i) map_q <= '0;
    else if (set_i) map_q[idx_i] <= 1'b1;
  end
endmodule

// File: rtl/cov_count.sv
module cov_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (inc_i && cnt_q != MAX)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cov_sum.sv
module cov_sum #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned CHILD_N = 2
) (
  input  logic [CNT_W-1:0]         own_i,
  input  logic [CHILD_N*CNT_W-1:0] child_i,
  output logic [CNT_W-1:0]         tot_o
);
  localparam int unsigned SW = CNT_W + $clog2(CHILD_N + 2);
  localparam logic [SW-1:0] MAX_W = SW'({CNT_W{1'b1}});

  logic [SW-1:0] acc;

  always_comb begin
    acc = SW'(own_i);
    for (int i = 0; i < CHILD_N; i++) acc += SW'(child_i[i*CNT_W +: CNT_W]);
    tot_o = (acc > MAX_W) ? {CNT_W{1'b1}} : acc[CNT_W-1:0];
  end
endmodule

// File: rtl/ctl_cov_mon.sv
module ctl_cov_mon #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned OFF_BASE = 0,
  parameter int unsigned OFF_STEP = 3,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned CHILD_N  = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic [NUM_REGS*REG_W-1:0]  ctl_i,
  input  logic [CHILD_N*CNT_W-1:0]   child_cnt_i,
  output logic [IDX_W-1:0]           hash_o,
  output logic                       new_o,
  output logic [CNT_W-1:0]           cnt_o,
  output logic [CNT_W-1:0]           tot_o
);
  logic [IDX_W-1:0] idx_w;
  logic             hit_w;
  logic             first_w;
  logic [IDX_W-1:0] hash_q;
  logic             new_q;

  cov_hash #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .IDX_W(IDX_W),
    .OFF_BASE(OFF_BASE), .OFF_STEP(OFF_STEP)
  ) u_hash (
    .ctl_i(ctl_i),
    .idx_o(idx_w)
  );

  cov_bitmap #(.IDX_W(IDX_W)) u_map (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .set_i (1'b1),
    .idx_i (idx_w),
    .hit_o (hit_w)
  );

  assign first_w = !hit_w && !clr_i;

  cov_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .inc_i (first_w),
    .cnt_o (cnt_o)
  );

  cov_sum #(.CNT_W(CNT_W), .CHILD_N(CHILD_N)) u_sum (
    .own_i  (cnt_o),
    .child_i(child_cnt_i),
    .tot_o  (tot_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hash_q <= '0;
      new_q  <= 1'b0;
    end else begin
      hash_q <= idx_w;
      new_q  <= first_w;
    end
  end

  assign hash_o = hash_q;
  assign new_o  = new_q;
endmodule

// File: rtl/ctl_cov_mon_chk.sv
module ctl_cov_mon_chk #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned CNT_W    = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      clr_i,
  input logic [NUM_REGS*REG_W-1:0] ctl_i,
  input logic                      new_o,
  input logic [CNT_W-1:0]          cnt_o,
  input logic [CNT_W-1:0]          tot_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_o == $past(cnt_o) + CNT_W'(new_o)) || (cnt_o == MAX));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == MAX && !clr_i) |=> cnt_o == MAX);

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0 && !new_o));

  assert_revisit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !clr_i && !$past(clr_i) && $stable(ctl_i)) |=> !new_o);

  always_comb begin
    if (rst_ni) assert_tot_ge_R6: assert (tot_o >= cnt_o);
  end
endmodule

bind ctl_cov_mon ctl_cov_mon_chk #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .clr_i (clr_i),
  .ctl_i (ctl_i),
  .new_o (new_o),
  .cnt_o (cnt_o),
  .tot_o (tot_o)
);

// File: tb/ctl_cov_mon_tb.sv
`timescale 1ns/1ps
module ctl_cov_mon_tb;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic [31:0] ctl_i = '0;
  logic [15:0] child_cnt_i = '0;
  logic [7:0]  hash_o;
  logic        new_o;
  logic [7:0]  cnt_o;
  logic [7:0]  tot_o;

  int total = 0;
  int bad = 0;
  bit ref_map [256];
  int ref_cnt = 0;

  always #HALF clk = ~clk;

  ctl_cov_mon u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr_i), .ctl_i(ctl_i),
    .child_cnt_i(child_cnt_i), .hash_o(hash_o), .new_o(new_o),
    .cnt_o(cnt_o), .tot_o(tot_o)
  );

  function automatic int hsh(logic [31:0] c);
    logic [15:0] t;
    logic [7:0]  acc = '0;
    for (int k = 0; k < 4; k++) begin
      t = {8'h00, c[k*8 +: 8]} << ((k * 3) % 8);
      acc ^= t[7:0];
    end
    return int'(acc);
  endfunction

  function automatic int tot_ref(int own, logic [15:0] ch);
    int s = own + int'(ch[7:0]) + int'(ch[15:8]);
    return (s > 255) ? 255 : s;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, check at next negedge
  task automatic step(logic [31:0] c, bit clr, string req);
    int h;
    int exp_new;
    ctl_i = c;
    clr_i = clr;
    @(posedge clk);
    h = hsh(c);
    if (clr) begin
      foreach (ref_map[i]) ref_map[i] = 1'b0;
      ref_cnt = 0;
      exp_new = 0;
    end else begin
      exp_new = ref_map[h] ? 0 : 1;
      ref_map[h] = 1'b1;
      if (exp_new == 1 && ref_cnt < 255) ref_cnt++;
    end
    @(negedge clk);
    chk({req, " R1 hash"}, int'(hash_o), h);
    chk({req, " new"}, int'(new_o), exp_new);
    chk({req, " cnt"}, int'(cnt_o), ref_cnt);
    chk({req, " R6 tot"}, int'(tot_o), tot_ref(ref_cnt, child_cnt_i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    foreach (ref_map[i]) ref_map[i] = 1'b0;
    ctl_i = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    chk("R7 hash", int'(hash_o), 0);
    chk("R7 new", int'(new_o), 0);
    chk("R7 cnt", int'(cnt_o), 0);
    rst_ni = 1'b1;

    // R3/R2 directed: first visit then revisit of same state
    step(32'h0000_0005, 1'b0, "R3 first");
    step(32'h0000_0005, 1'b0, "R2 revisit");
    // R8: distinct states back to back
    step(32'h0100_0000, 1'b0, "R8 a");
    step(32'h0001_0000, 1'b0, "R8 b");
    step(32'h0000_0100, 1'b0, "R8 c");
    // aliasing: field1=1 (shift 3) equals field0=8
    step(32'h0000_0008, 1'b0, "R1 alias a");
    step(32'h0000_0100, 1'b0, "R2 alias b");

    // random phase
    for (int i = 0; i < 800; i++) begin
      logic [31:0] c;
      bit cl;
      child_cnt_i = 16'($urandom_range(0, 60)) | (16'($urandom_range(0, 60)) << 8);
      if (($urandom % 4) == 0) c = ctl_i;
      else c = $urandom & 32'h0303_0F0F;
      cl = ($urandom % 60) == 0;
      step(c, cl, cl ? "R5 rnd" : "R3 rnd");
    end

    // R5: clear then confirm the cleared state counts as new again
    child_cnt_i = '0;
    step(32'h0000_0011, 1'b0, "R3 pre");
    step(32'h0000_0011, 1'b1, "R5 clr");
    step(32'h0000_0011, 1'b0, "R5 after");

    // R4: fill all 256 slots through field 0 (shift 0)
    step(32'h0, 1'b1, "R5 clr2");
    for (int v = 0; v < 256; v++) step(32'(v), 1'b0, v >= 254 ? "R4 sat" : "R8 sweep");
    chk("R4 cnt held", int'(cnt_o), 255);
    step(32'h0000_0007, 1'b0, "R4 revisit");

    // R6 saturation of the sum
    child_cnt_i = 16'h64C8;
    #1 chk("R6 tot sat", int'(tot_o), 255);
    step(32'h0, 1'b1, "R5 clr3");
    child_cnt_i = 16'h0A14;
    #1 chk("R6 tot sum", int'(tot_o), 30);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule